// File: doc/BRIEF.md
# Register-Register Calculation Unit

This block decodes and executes the register-to-register calculation group of a 32-bit RISC core. Each cycle in which `valid_i` is high and no divide is in flight, it takes one instruction word, the two source operand values read from the register file, the current carry bit and the compare flag. The result, the destination register index and the updated carry and overflow bits are returned one cycle later, together with a one-cycle write strobe for the register file.

Decoding works in two levels. A 2-bit class field picks the operation class, and a 4-bit operation field picks the operation within it. For shifts and extensions, a further 2-bit selector refines the choice. The following field positions are fixed: operation field bits 3:0, selector bits 7:6, class field bits 9:8, second source index bits 15:11, first source index bits 20:16 and destination index bits 25:21. Arithmetic, logic, shift, extension, conditional move, bit-find and multiply produce their result in one cycle. Signed and unsigned divide run on an iterative radix-2 unit that reports `busy_o` while it works and `done_o` when its result is written. Any field combination not listed below raises `illegal_o` and suppresses the write.

Top module: `rr_calc_unit`

## Requirements
- R1: An accepted single-cycle instruction presents its result, `rd_o` (taken from bits 25:21), carry and overflow on the cycle after issue, with `wr_en_o` high for exactly that one cycle. Without `valid_i`, nothing is written.
- R2: Class 0 with operation codes 0, 1 and 2 performs add, add-with-carry-in and subtract. For add and add-with-carry, carry out is bit 32 of the sum. For subtract, carry out is the borrow (A < B unsigned). Overflow signals signed overflow.
- R3: Class 0 with operation codes 3, 4 and 5 performs bitwise AND, OR and XOR. Carry passes through unchanged and overflow is 0.
- R4: Class 0 with operation code 8 shifts A by B[4:0]. The selector chooses among four shifts: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right.
- R5: Class 0 with operation code 0xC extends A. The selector chooses: 0 sign-extends bits 15:0, 1 sign-extends bits 7:0, 2 zero-extends bits 15:0 and 3 zero-extends bits 7:0.
- R6: Class 0 with operation code 0xD and selector 0 or 1 passes A through unchanged. These are the word sign-extend and word zero-extend operations.
- R7: Class 0 with operation code 0xE returns A when the compare flag is 1 and B when it is 0.
- R8: Class 0 with operation code 0xF returns the 1-based index of the lowest set bit of A, or 0 when A is zero.
- R9: Class 1 with operation code 0xF returns the 1-based index of the highest set bit of A, or 0 when A is zero.
- R10: Class 3 with operation code 6 performs a signed multiply and with code 0xB an unsigned multiply. The result is the low 32 bits of the product. Overflow is set when the full product does not fit in 32 bits of the respective signedness.
- R11: Class 3 with operation code 9 performs a signed divide and with code 0xA an unsigned divide, both with a truncated quotient. `busy_o` is high for 32 cycles after issue. Then `done_o` and `wr_en_o` pulse for one cycle with the quotient and the destination index of the divide.
- R12: A divide by zero returns all-ones with overflow set, using the same 32-cycle timing.
- R13: Every other combination pulses `illegal_o` for one cycle and does not write. This includes all of class 2, class 0 code 0xD with selector 2 or 3, class 0 codes 6, 7, 9, 0xA and 0xB, class 1 codes other than 0xF, and class 3 codes other than 6, 9, 0xA and 0xB.
- R14: After reset, all outputs are 0. An instruction presented while `busy_o` is high is ignored: it produces no write, no illegal pulse and no change to the pending divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | First source operand value |
| opb_i | input | 32 | Second source operand value |
| carry_i | input | 1 | Current carry bit |
| flag_i | input | 1 | Current compare flag |
| result_o | output | 32 | Result value |
| rd_o | output | 5 | Destination register index |
| carry_o | output | 1 | Updated carry |
| ovf_o | output | 1 | Overflow indication |
| wr_en_o | output | 1 | Register write strobe |
| illegal_o | output | 1 | Illegal-instruction pulse |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | Divide result present |

## Verification
The assertions assume that the issuing stage respects `busy_o`. They also assume that a write strobe appears only as the consequence of an accepted instruction issued one cycle earlier, or of a divide that has just finished. The bench drives every instruction for exactly one cycle at the falling edge and keeps `valid_i` low between instructions. Only the one deliberate back-to-back case offers an instruction while a divide is running, which exercises the ignore rule without desynchronising the expected timing.

// File: rtl/rr_calc_pkg.sv
package rr_calc_pkg;
  localparam int unsigned REG_AW = 5;

  localparam int unsigned F_OP0_LO = 0;
  localparam int unsigned F_OP2_LO = 6;
  localparam int unsigned F_OP1_LO = 8;
  localparam int unsigned F_RB_LO  = 11;
  localparam int unsigned F_RA_LO  = 16;
  localparam int unsigned F_RD_LO  = 21;

  typedef enum logic [4:0] {
    OP_ADD, OP_ADDC, OP_SUB, OP_AND, OP_OR, OP_XOR,
    OP_SLL, OP_SRL, OP_SRA, OP_ROR,
    OP_EXTHS, OP_EXTBS, OP_EXTHZ, OP_EXTBZ, OP_PASS,
    OP_CMOV, OP_FF1, OP_FL1,
    OP_MUL, OP_MULU, OP_DIV, OP_DIVU, OP_NONE
  } calc_op_e;
endpackage

// File: rtl/rr_calc_decode.sv
module rr_calc_decode
  import rr_calc_pkg::*;
(
  input  logic [31:0]       insn_i,
  output calc_op_e          op_o,
  output logic              legal_o,
  output logic [REG_AW-1:0] rd_o
);
  logic [3:0] op0;
  logic [1:0] op1, op2;
  logic       unused_bits;

  assign op0  = insn_i[F_OP0_LO +: 4];
  assign op2  = insn_i[F_OP2_LO +: 2];
  assign op1  = insn_i[F_OP1_LO +: 2];
  assign rd_o = insn_i[F_RD_LO +: REG_AW];
  assign unused_bits = ^{insn_i[31:26], insn_i[20:10], insn_i[5:4]};

  // class first, operation second
  always_comb begin
    op_o = OP_NONE;
    case (op1)
      2'd0: begin
        case (op0)
          4'h0: op_o = OP_ADD;
          4'h1: op_o = OP_ADDC;
          4'h2: op_o = OP_SUB;
          4'h3: op_o = OP_AND;
          4'h4: op_o = OP_OR;
          4'h5: op_o = OP_XOR;
          4'h8: case (op2)
                  2'd0: op_o = OP_SLL;
                  2'd1: op_o = OP_SRL;
                  2'd2: op_o = OP_SRA;
                  default: op_o = OP_ROR;
                endcase
          4'hC: case (op2)
                  2'd0: op_o = OP_EXTHS;
                  2'd1: op_o = OP_EXTBS;
                  2'd2: op_o = OP_EXTHZ;
                  default: op_o = OP_EXTBZ;
                endcase
          4'hD: if (!op2[1]) op_o = OP_PASS;
          4'hE: op_o = OP_CMOV;
          4'hF: op_o = OP_FF1;
          default: op_o = OP_NONE;
        endcase
      end
      2'd1: if (op0 == 4'hF) op_o = OP_FL1;
      2'd3: begin
        case (op0)
          4'h6: op_o = OP_MUL;
          4'h9: op_o = OP_DIV;
          4'hA: op_o = OP_DIVU;
          4'hB: op_o = OP_MULU;
          default: op_o = OP_NONE;
        endcase
      end
      default: op_o = OP_NONE;
    endcase
  end

  assign legal_o = (op_o != OP_NONE);
endmodule

// File: rtl/rr_calc_bitfind.sv
module rr_calc_bitfind #(
  parameter int unsigned W    = 32,
  localparam int unsigned IDXW = $clog2(W) + 1
) (
  input  logic [W-1:0]    val_i,
  output logic [IDXW-1:0] low_o,
  output logic [IDXW-1:0] high_o
);
  always_comb begin
    low_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (val_i[i]) low_o = IDXW'(i + 1);
    end
  end

  always_comb begin
    high_o = '0;
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) high_o = IDXW'(i + 1);
    end
  end
endmodule

// File: rtl/rr_calc_exec.sv
module rr_calc_exec
  import rr_calc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  calc_op_e     op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         flag_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int unsigned SHW  = $clog2(W);
  localparam int unsigned IDXW = $clog2(W) + 1;

  logic [SHW-1:0]      sh;
  logic [W:0]          sum, diff;
  logic [2*W-1:0]      rot, pu;
  logic signed [2*W-1:0] sa, sb, ps;
  logic [IDXW-1:0]     ff_low, ff_high;

  assign sh   = b_i[SHW-1:0];
  assign sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, (op_i == OP_ADDC) & cin_i};
  assign diff = {1'b0, a_i} - {1'b0, b_i};
  assign rot  = {a_i, a_i} >> sh;
  assign sa   = {{W{a_i[W-1]}}, a_i};
  assign sb   = {{W{b_i[W-1]}}, b_i};
  assign ps   = sa * sb;
  assign pu   = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};

  rr_calc_bitfind #(.W(W)) i_bitfind (
    .val_i  (a_i),
    .low_o  (ff_low),
    .high_o (ff_high)
  );

  always_comb begin
    res_o  = a_i;
    cout_o = cin_i;
    ovf_o  = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC: begin
        res_o  = sum[W-1:0];
        cout_o = sum[W];
        ovf_o  = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
      end
      OP_SUB: begin
        res_o  = diff[W-1:0];
        cout_o = diff[W];
        ovf_o  = (a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1]);
      end
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_SLL:   res_o = a_i << sh;
      OP_SRL:   res_o = a_i >> sh;
      OP_SRA:   res_o = $signed(a_i) >>> sh;
      OP_ROR:   res_o = rot[W-1:0];
      OP_EXTHS: res_o = {{(W-16){a_i[15]}}, a_i[15:0]};
      OP_EXTBS: res_o = {{(W-8){a_i[7]}}, a_i[7:0]};
      OP_EXTHZ: res_o = {{(W-16){1'b0}}, a_i[15:0]};
      OP_EXTBZ: res_o = {{(W-8){1'b0}}, a_i[7:0]};
      OP_PASS:  res_o = a_i;
      OP_CMOV:  res_o = flag_i ? a_i : b_i;
      OP_FF1:   res_o = {{(W-IDXW){1'b0}}, ff_low};
      OP_FL1:   res_o = {{(W-IDXW){1'b0}}, ff_high};
      OP_MUL: begin
        res_o = ps[W-1:0];
        ovf_o = ~(&ps[2*W-1:W-1]) & (|ps[2*W-1:W-1]);
      end
      OP_MULU: begin
        res_o = pu[W-1:0];
        ovf_o = |pu[2*W-1:W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rr_calc_divider.sv
module rr_calc_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dz_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CNTW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CNTW-1:0] cnt_q;
  logic          neg_q, dz_q;
  logic [W:0]    trial, trial_sub;
  logic [W-1:0]  rem_n, quo_n;
  logic          fits;

  assign trial     = {rem_q, quo_q[W-1]};
  assign trial_sub = trial - {1'b0, dvs_q};
  assign fits      = (trial >= {1'b0, dvs_q});
  assign rem_n     = fits ? trial_sub[W-1:0] : trial[W-1:0];
  assign quo_n     = {quo_q[W-2:0], fits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      dz_q   <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      dz_o   <= 1'b0;
      quot_o <= '0;
    end else if (busy_o) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        dz_o   <= dz_q;
        quot_o <= dz_q ? '1 : (neg_q ? -quo_n : quo_n);
      end
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= (signed_i && dividend_i[W-1]) ? -dividend_i : dividend_i;
        dvs_q  <= (signed_i && divisor_i[W-1]) ? -divisor_i : divisor_i;
        neg_q  <= signed_i && (dividend_i[W-1] ^ divisor_i[W-1]);
        dz_q   <= (divisor_i == '0);
        cnt_q  <= CNTW'(W);
        busy_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_calc_unit.sv
module rr_calc_unit
  import rr_calc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  input  logic              carry_i,
  input  logic              flag_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [REG_AW-1:0] rd_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              wr_en_o,
  output logic              illegal_o,
  output logic              busy_o,
  output logic              done_o
);
  calc_op_e          dec_op;
  logic              dec_legal, is_div, issue, do_single, do_div;
  logic [REG_AW-1:0] dec_rd;
  logic [WIDTH-1:0]  ex_res, div_quot;
  logic              ex_cy, ex_ov, div_busy, div_done, div_dz;

  logic [WIDTH-1:0]  result_q;
  logic [REG_AW-1:0] rd_q, div_rd_q;
  logic              carry_q, ovf_q, wr_q, ill_q, div_cy_q;

  rr_calc_decode i_decode (
    .insn_i  (insn_i),
    .op_o    (dec_op),
    .legal_o (dec_legal),
    .rd_o    (dec_rd)
  );

  rr_calc_exec #(.W(WIDTH)) i_exec (
    .op_i   (dec_op),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .cin_i  (carry_i),
    .flag_i (flag_i),
    .res_o  (ex_res),
    .cout_o (ex_cy),
    .ovf_o  (ex_ov)
  );

  assign is_div    = (dec_op == OP_DIV) || (dec_op == OP_DIVU);
  assign issue     = valid_i && !div_busy;
  assign do_single = issue && dec_legal && !is_div;
  assign do_div    = issue && is_div;

  rr_calc_divider #(.W(WIDTH)) i_divider (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (do_div),
    .signed_i   (dec_op == OP_DIV),
    .dividend_i (opa_i),
    .divisor_i  (opb_i),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .dz_o       (div_dz),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      rd_q     <= '0;
      carry_q  <= 1'b0;
      ovf_q    <= 1'b0;
      wr_q     <= 1'b0;
      ill_q    <= 1'b0;
      div_rd_q <= '0;
      div_cy_q <= 1'b0;
    end else begin
      wr_q  <= do_single;
      ill_q <= issue && !dec_legal;
      if (do_single) begin
        result_q <= ex_res;
        rd_q     <= dec_rd;
        carry_q  <= ex_cy;
        ovf_q    <= ex_ov;
      end
      if (do_div) begin
        div_rd_q <= dec_rd;
        div_cy_q <= carry_i;
      end
    end
  end

  // divide completion takes the output slot; the issue side is blocked meanwhile
  assign result_o  = div_done ? div_quot : result_q;
  assign rd_o      = div_done ? div_rd_q : rd_q;
  assign carry_o   = div_done ? div_cy_q : carry_q;
  assign ovf_o     = div_done ? div_dz   : ovf_q;
  assign wr_en_o   = wr_q | div_done;
  assign illegal_o = ill_q;
  assign busy_o    = div_busy;
  assign done_o    = div_done;
endmodule

// File: rtl/rr_calc_checker.sv
module rr_calc_checker #(
  parameter int unsigned DIV_CYCLES = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic wr_en_o,
  input logic illegal_o,
  input logic busy_o,
  input logic done_o
);
  localparam int unsigned CW = $clog2(DIV_CYCLES + 2) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  a_r13_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o);

  a_r1_write_needs_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !done_o) |-> $past(valid_i));

  a_r11_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o && wr_en_o));

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == CW'(DIV_CYCLES)));
endmodule

bind rr_calc_unit rr_calc_checker #(.DIV_CYCLES(WIDTH)) i_rr_calc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .wr_en_o   (wr_en_o),
  .illegal_o (illegal_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_rr_calc_unit.sv
module test_rr_calc_unit;
  typedef struct packed {
    logic [1:0]  op1;
    logic [3:0]  op0;
    logic [1:0]  op2;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic        flg;
    logic [31:0] res;
    logic        cy;
    logic        ov;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'h0, 2'd0, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 add carry
    '{2'd0, 4'h0, 2'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0, 4'd2}, // R2 add ovf, cin unused
    '{2'd0, 4'h1, 2'd0, 32'h00000001, 32'h00000002, 1'b1, 1'b0, 32'h00000004, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 addc
    '{2'd0, 4'h1, 2'd0, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 addc wrap
    '{2'd0, 4'h2, 2'd0, 32'h00000003, 32'h00000005, 1'b0, 1'b0, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 sub borrow
    '{2'd0, 4'h2, 2'd0, 32'h80000000, 32'h00000001, 1'b0, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b0, 4'd2}, // R2 sub ovf
    '{2'd0, 4'h3, 2'd0, 32'hF0F0F0F0, 32'hFF00FF00, 1'b1, 1'b0, 32'hF000F000, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 and
    '{2'd0, 4'h4, 2'd0, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 1'b0, 32'hFFF0FFF0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 or
    '{2'd0, 4'h5, 2'd0, 32'hF0F0F0F0, 32'hFF00FF00, 1'b1, 1'b0, 32'h0FF00FF0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 xor
    '{2'd0, 4'h8, 2'd0, 32'h00000001, 32'h00000021, 1'b0, 1'b0, 32'h00000002, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 sll, amount masked
    '{2'd0, 4'h8, 2'd1, 32'h80000000, 32'h00000004, 1'b0, 1'b0, 32'h08000000, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 srl
    '{2'd0, 4'h8, 2'd2, 32'h80000000, 32'hFFFFFFE4, 1'b0, 1'b0, 32'hF8000000, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 sra
    '{2'd0, 4'h8, 2'd3, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 32'h80000000, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 ror
    '{2'd0, 4'hC, 2'd0, 32'h12348001, 32'h00000000, 1'b0, 1'b0, 32'hFFFF8001, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{2'd0, 4'hC, 2'd1, 32'h00000080, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFF80, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{2'd0, 4'hC, 2'd2, 32'hFFFF8001, 32'h00000000, 1'b0, 1'b0, 32'h00008001, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{2'd0, 4'hC, 2'd3, 32'hFFFFFF80, 32'h00000000, 1'b0, 1'b0, 32'h00000080, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{2'd0, 4'hD, 2'd0, 32'h89ABCDEF, 32'h00000000, 1'b0, 1'b0, 32'h89ABCDEF, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
    '{2'd0, 4'hD, 2'd1, 32'h89ABCDEF, 32'h00000000, 1'b1, 1'b0, 32'h89ABCDEF, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
    '{2'd0, 4'hE, 2'd0, 32'h0000AAAA, 32'h00005555, 1'b0, 1'b1, 32'h0000AAAA, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 flag set
    '{2'd0, 4'hE, 2'd0, 32'h0000AAAA, 32'h00005555, 1'b0, 1'b0, 32'h00005555, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 flag clear
    '{2'd0, 4'hF, 2'd0, 32'h00000050, 32'h00000000, 1'b0, 1'b0, 32'h00000005, 1'b0, 1'b0, 1'b0, 4'd8}, // R8
    '{2'd0, 4'hF, 2'd0, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 zero
    '{2'd0, 4'hF, 2'd0, 32'h80000000, 32'h00000000, 1'b0, 1'b0, 32'h00000020, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 top bit
    '{2'd1, 4'hF, 2'd0, 32'h00000050, 32'h00000000, 1'b0, 1'b0, 32'h00000007, 1'b0, 1'b0, 1'b0, 4'd9}, // R9
    '{2'd1, 4'hF, 2'd0, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 zero
    '{2'd1, 4'hF, 2'd0, 32'h00000001, 32'h00000000, 1'b0, 1'b0, 32'h00000001, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 bit 0
    '{2'd3, 4'h6, 2'd0, 32'hFFFFFFFE, 32'h00000003, 1'b0, 1'b0, 32'hFFFFFFFA, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{2'd3, 4'h6, 2'd0, 32'h00010000, 32'h00010000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10
    '{2'd3, 4'hB, 2'd0, 32'hFFFFFFFF, 32'h00000002, 1'b1, 1'b0, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
    '{2'd3, 4'hB, 2'd0, 32'h00000003, 32'h00000004, 1'b0, 1'b0, 32'h0000000C, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{2'd2, 4'h0, 2'd0, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd13}, // R13 class 2
    '{2'd0, 4'hD, 2'd2, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd13}, // R13
    '{2'd0, 4'hD, 2'd3, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd13}, // R13
    '{2'd0, 4'h6, 2'd0, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd13}, // R13
    '{2'd3, 4'h0, 2'd0, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd13}, // R13
    '{2'd1, 4'h0, 2'd0, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd13}  // R13
  };

  logic        clk, rst_n, valid;
  logic [31:0] insn, opa, opb;
  logic        cin, flg;
  logic [31:0] result;
  logic [4:0]  rd;
  logic        cy, ov, wr, ill, busy, done;
  int          n_chk, n_fail;
  bit          finished;

  rr_calc_unit i_rr_calc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .opa_i(opa), .opb_i(opb), .carry_i(cin), .flag_i(flg),
    .result_o(result), .rd_o(rd), .carry_o(cy), .ovf_o(ov),
    .wr_en_o(wr), .illegal_o(ill), .busy_o(busy), .done_o(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk(logic [1:0] op1, logic [3:0] op0, logic [1:0] op2, logic [4:0] d);
    return {6'h38, d, 5'd1, 5'd2, 1'b0, op1, op2, 2'b00, op0};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic c, logic f);
    @(negedge clk);
    insn = w; opa = a; opb = b; cin = c; flg = f; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    valid = 1'b0; insn = '0; opa = '0; opb = '0; cin = 1'b0; flg = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14 reset state
    check({result, rd, cy, ov, wr, ill, busy, done} == '0, "R14 reset outputs",
          64'({result, rd, cy, ov, wr, ill, busy, done}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [4:0] d;
      bit ok;
      string tag;
      v = VECS[i];
      d = 5'(i) ^ 5'h15;
      issue(mk(v.op1, v.op0, v.op2, d), v.a, v.b, v.cin, v.flg);
      if (v.ill)
        ok = ill && !wr;
      else
        ok = !ill && wr && result == v.res && cy == v.cy && ov == v.ov && rd == d;
      tag = $sformatf("R%0d vector %0d (res,cy,ov,wr,ill,rd)", v.req, i);
      check(ok, tag, {result, 8'(cy), 8'(ov), 3'(wr), ill, 3'(0), rd},
            {v.res, 8'(v.cy), 8'(v.ov), 3'(!v.ill), v.ill, 3'(0), d});
    end

    // R1 / R13 strobes last one cycle
    @(negedge clk);
    check(!wr && !ill, "R1 R13 strobes drop after one cycle", 64'({wr, ill}), 64'd0);

    // R1 no write without valid
    insn = mk(2'd0, 4'h0, 2'd0, 5'd7); opa = 32'd1; opb = 32'd1;
    @(negedge clk);
    check(!wr, "R1 no write without valid", 64'(wr), 64'd0);

    // R11 signed divide: -7 / 2 = -3
    issue(mk(2'd3, 4'h9, 2'd0, 5'd4), 32'hFFFFFFF9, 32'd2, 1'b1, 1'b0);
    check(busy && !wr, "R11 busy after issue", 64'({busy, wr}), 64'b10);
    wait_done(n);
    check(n == 32, "R11 divide latency", 64'(n), 64'd32);
    check(done && wr && result == 32'hFFFFFFFD && rd == 5'd4 && !ov && cy && !busy,
          "R11 signed quotient", {result, 27'(0), rd}, {32'hFFFFFFFD, 27'(0), 5'd4});
    @(negedge clk);
    check(!done && !wr, "R11 done pulse", 64'({done, wr}), 64'd0);

    // R11 signed 7 / -2 = -3
    issue(mk(2'd3, 4'h9, 2'd0, 5'd5), 32'd7, 32'hFFFFFFFE, 1'b0, 1'b0);
    wait_done(n);
    check(result == 32'hFFFFFFFD && !ov, "R11 signed negative divisor", 64'(result), 64'hFFFFFFFD);

    // R11 unsigned all-ones / 2
    issue(mk(2'd3, 4'hA, 2'd0, 5'd6), 32'hFFFFFFFF, 32'd2, 1'b0, 1'b0);
    wait_done(n);
    check(result == 32'h7FFFFFFF && wr, "R11 unsigned quotient", 64'(result), 64'h7FFFFFFF);

    // R12 divide by zero
    issue(mk(2'd3, 4'h9, 2'd0, 5'd8), 32'd123, 32'd0, 1'b0, 1'b0);
    wait_done(n);
    check(n == 32 && result == 32'hFFFFFFFF && ov && wr, "R12 divide by zero",
          {32'(n), result}, {32'd32, 32'hFFFFFFFF});

    // R14 issue while busy is ignored; divide continues
    issue(mk(2'd3, 4'hA, 2'd0, 5'd9), 32'd100, 32'd7, 1'b0, 1'b0);
    insn = mk(2'd0, 4'h0, 2'd0, 5'd3); opa = 32'd1; opb = 32'd1; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(!wr && !ill && busy, "R14 issue while busy ignored", 64'({wr, ill, busy}), 64'b001);
    insn = mk(2'd2, 4'h0, 2'd0, 5'd3); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(!ill && !wr, "R14 illegal while busy ignored", 64'({ill, wr}), 64'd0);
    wait_done(n);
    check(n == 30 && result == 32'd14 && rd == 5'd9, "R14 pending divide intact",
          {32'(n), result}, {32'd30, 32'd14});

    @(negedge clk);
    finish_run();
  end
endmodule